// File: doc/BRIEF.md
# Local-to-PCI Address Window Translator

This block sits on the local-bus side of a PCI host bridge. It turns each local address it is handed into a PCI address, a PCI cycle type and a few per-window attributes. It does this through a small set of programmable windows. Each window is a pair of registers. The base register says which local range the window claims and how large that range is. The map register says where that range lands on the PCI bus and what kind of PCI cycle it produces.

There are two general memory windows and one I/O window. A memory window spans a power of two from 1 MB to 2 GB, chosen by a 4-bit size code. The I/O window always spans 16 MB. When windows overlap, the lowest-numbered enabled window that contains the address wins. Software can therefore enlarge window 0 over window 1, reprogram window 1 while it is hidden, and then shrink window 0 again to expose the new mapping.

Software writes one register per cycle through a simple select/data port. Lookups are presented with a request strobe, and the result appears on registered outputs one cycle later.

Top module: `lpw_xlate`

## Requirements
- R1: After reset every window is disabled, so every lookup misses until software sets an enable bit. A reset in mid-run clears all programmed windows again.
- R2: Register select codes are 0 = base of window 0, 1 = map of window 0, 2 = base of window 1, 3 = map of window 1, 4 = base of window 2, 5 = map of window 2. In a memory-window base, bits 31:20 give local address bits 31:20, bits 9:8 the swap attribute, bits 7:4 the size code, bit 3 prefetch and bit 0 enable. A written value is used by the lookup presented in the very next cycle. A window whose enable bit is 0 never matches.
- R3: A memory window with size code c spans 2^(20+c) bytes for c from 0 to 11. Codes 12 to 15 act as 11 (2 GB). Base address bits inside the span are ignored when matching.
- R4: In a memory-window map, bits 15:4 give PCI address bits 31:20, bits 3:1 the cycle type and bit 0 the low-address override flag. Cycle types are encoded 0 = interrupt acknowledge, 1 = I/O, 3 = memory, 5 = configuration, 6 = memory read multiple. The PCI address takes its bits above the span from the map and its bits below the span from the local address.
- R5: For window 2, base bits 15:8 give local address bits 31:24, bits 7:6 the swap attribute and bit 0 enable. Map bits 15:8 give PCI address bits 31:24. The window spans exactly 16 MB and passes local bits 23:0 through. It always reports cycle type 1 (I/O), with prefetch 0 and override 0.
- R6: When several enabled windows contain the address, the lowest-numbered one is used (0 before 1 before 2).
- R7: A lookup that no enabled window contains sets the miss output. It drives the window index, PCI address, cycle type, prefetch, override and swap outputs to zero.
- R8: Outputs are registered. A request presented in one cycle produces out_vld_o with exactly one of hit_o or miss_o in the next cycle. Without a request, all outputs are zero.
- R9: On a hit, prefetch_o, swap_o and ad_low_o come from the matching window's registers, and win_o gives its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select code |
| cfg_wdata_i | input | 32 | Register write data |
| lb_req_i | input | 1 | Lookup request |
| lb_addr_i | input | 32 | Local address to translate |
| out_vld_o | output | 1 | Result valid (request seen last cycle) |
| hit_o | output | 1 | Some enabled window matched |
| miss_o | output | 1 | No enabled window matched |
| win_o | output | 2 | Index of the selected window |
| pci_addr_o | output | 32 | Translated PCI address |
| cyc_type_o | output | 3 | PCI cycle type |
| prefetch_o | output | 1 | Prefetch attribute of the selected window |
| ad_low_o | output | 1 | Low-address override flag of the selected window |
| swap_o | output | 2 | Swap attribute of the selected window |

## Verification
The bench builds the block with its default parameters: two memory windows plus the I/O window, and size codes capped at 11. At this size all sixteen size codes can be swept, each with probes on both edges of its span and just outside them. A lookup in every 16 MB region of the local space can also be repeated for each window arrangement used in the enlarge, hide, reprogram and shrink sequence. Expected results come from an interval model in the bench: a range test followed by an offset add. The RTL, by contrast, uses a masked compare and a bit merge.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  localparam int AW       = 32;
  localparam int GRAN_LSB = 20;
  localparam int IO_LSB   = 24;
  localparam int HI_W     = AW - GRAN_LSB;
  localparam int IO_HI_W  = AW - IO_LSB;
  localparam int SZ_W     = 4;
  localparam int TYP_W    = 3;
  localparam int SWP_W    = 2;

  localparam logic [TYP_W-1:0] CYC_IACK = 3'd0;
  localparam logic [TYP_W-1:0] CYC_IO   = 3'd1;
  localparam logic [TYP_W-1:0] CYC_MEM  = 3'd3;
  localparam logic [TYP_W-1:0] CYC_CFG  = 3'd5;
  localparam logic [TYP_W-1:0] CYC_MRM  = 3'd6;

  typedef struct packed {
    logic [HI_W-1:0]  base;
    logic [SWP_W-1:0] swap;
    logic [SZ_W-1:0]  size;
    logic             pf;
    logic             en;
    logic [HI_W-1:0]  map;
    logic [TYP_W-1:0] typ;
    logic             low;
  } mem_cfg_t;

  typedef struct packed {
    logic [IO_HI_W-1:0] base;
    logic [SWP_W-1:0]   swap;
    logic               en;
    logic [IO_HI_W-1:0] map;
  } io_cfg_t;

  typedef struct packed {
    logic             hit;
    logic [AW-1:0]    pa;
    logic [TYP_W-1:0] typ;
    logic             pf;
    logic             low;
    logic [SWP_W-1:0] swap;
  } xres_t;
endpackage

// File: rtl/lpw_regfile.sv
module lpw_regfile
  import lpw_pkg::*;
#(
  parameter int NUM_MEM_WIN = 2,
  parameter int SEL_W       = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  output mem_cfg_t        mem_cfg [NUM_MEM_WIN],
  output io_cfg_t         io_cfg
);
  localparam int IO_BASE_SEL = 2 * NUM_MEM_WIN;
  localparam int IO_MAP_SEL  = 2 * NUM_MEM_WIN + 1;

  // bits 19:16 carry no field in any register
  logic unused_wbits;
  assign unused_wbits = ^cfg_wdata[19:16];

  for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem
    always_ff @(posedge clk) begin
      if (rst) begin
        mem_cfg[w] <= '0;
      end else if (cfg_we && cfg_sel == SEL_W'(2 * w)) begin
        mem_cfg[w].base <= cfg_wdata[AW-1:GRAN_LSB];
        mem_cfg[w].swap <= cfg_wdata[9:8];
        mem_cfg[w].size <= cfg_wdata[7:4];
        mem_cfg[w].pf   <= cfg_wdata[3];
        mem_cfg[w].en   <= cfg_wdata[0];
      end else if (cfg_we && cfg_sel == SEL_W'(2 * w + 1)) begin
        mem_cfg[w].map  <= cfg_wdata[15:4];
        mem_cfg[w].typ  <= cfg_wdata[3:1];
        mem_cfg[w].low  <= cfg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_cfg <= '0;
    end else if (cfg_we && cfg_sel == SEL_W'(IO_BASE_SEL)) begin
      io_cfg.base <= cfg_wdata[15:8];
      io_cfg.swap <= cfg_wdata[7:6];
      io_cfg.en   <= cfg_wdata[0];
    end else if (cfg_we && cfg_sel == SEL_W'(IO_MAP_SEL)) begin
      io_cfg.map  <= cfg_wdata[15:8];
    end
  end
endmodule

// File: rtl/lpw_mem_win.sv
module lpw_mem_win
  import lpw_pkg::*;
#(
  parameter int SIZE_CODE_MAX = 11
) (
  input  mem_cfg_t      cfg,
  input  logic [AW-1:0] addr,
  output xres_t         res
);
  logic [SZ_W-1:0] eff_code;
  logic [HI_W-1:0] keep_hi;
  logic [HI_W-1:0] pa_hi;
  logic            match;

  always_comb begin
    eff_code = (cfg.size > SZ_W'(SIZE_CODE_MAX)) ? SZ_W'(SIZE_CODE_MAX) : cfg.size;
    keep_hi  = {HI_W{1'b1}} << eff_code;
    match    = cfg.en && (((addr[AW-1:GRAN_LSB] ^ cfg.base) & keep_hi) == '0);
    pa_hi    = (cfg.map & keep_hi) | (addr[AW-1:GRAN_LSB] & ~keep_hi);
    res      = '0;
    if (match) begin
      res.hit  = 1'b1;
      res.pa   = {pa_hi, addr[GRAN_LSB-1:0]};
      res.typ  = cfg.typ;
      res.pf   = cfg.pf;
      res.low  = cfg.low;
      res.swap = cfg.swap;
    end
  end
endmodule

// File: rtl/lpw_io_win.sv
module lpw_io_win
  import lpw_pkg::*;
(
  input  io_cfg_t       cfg,
  input  logic [AW-1:0] addr,
  output xres_t         res
);
  logic match;

  always_comb begin
    match = cfg.en && (addr[AW-1:IO_LSB] == cfg.base);
    res   = '0;
    if (match) begin
      res.hit  = 1'b1;
      res.pa   = {cfg.map, addr[IO_LSB-1:0]};
      res.typ  = CYC_IO;
      res.swap = cfg.swap;
    end
  end
endmodule

// File: rtl/lpw_pick.sv
module lpw_pick
  import lpw_pkg::*;
#(
  parameter int NWIN  = 3,
  parameter int WIN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  xres_t            res [NWIN],
  output logic             out_vld,
  output logic             hit,
  output logic             miss,
  output logic [WIN_W-1:0] win,
  output logic [AW-1:0]    pa,
  output logic [TYP_W-1:0] typ,
  output logic             pf,
  output logic             low,
  output logic [SWP_W-1:0] swap
);
  xres_t            pick;
  logic [WIN_W-1:0] pick_idx;
  logic [NWIN-1:0]  hit_vec;
  logic [NWIN-1:0]  lower_m;

  for (genvar k = 0; k < NWIN; k++) begin : g_hv
    assign hit_vec[k] = res[k].hit;
  end

  // lowest index wins: scan downward, later assignment overrides
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    for (int k = NWIN - 1; k >= 0; k--) begin
      if (res[k].hit) begin
        pick     = res[k];
        pick_idx = WIN_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      hit     <= 1'b0;
      miss    <= 1'b0;
      win     <= '0;
      pa      <= '0;
      typ     <= '0;
      pf      <= 1'b0;
      low     <= 1'b0;
      swap    <= '0;
    end else begin
      out_vld <= req;
      hit     <= req && pick.hit;
      miss    <= req && !pick.hit;
      win     <= (req && pick.hit) ? pick_idx : '0;
      pa      <= req ? pick.pa   : '0;
      typ     <= req ? pick.typ  : '0;
      pf      <= req ? pick.pf   : 1'b0;
      low     <= req ? pick.low  : 1'b0;
      swap    <= req ? pick.swap : '0;
    end
  end

  assign lower_m = (NWIN'(1) << win) - NWIN'(1);

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (hit ^ miss));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (!hit && !miss && pa == '0));
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
    miss |-> (pa == '0 && typ == '0 && !pf && !low && swap == '0 && win == '0));
  a_r6_first_match: assert property (@(posedge clk) disable iff (rst)
    hit |-> (($past(hit_vec) & lower_m) == '0));
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hit && !out_vld));
endmodule

// File: rtl/lpw_xlate.sv
module lpw_xlate
  import lpw_pkg::*;
#(
  parameter int NUM_MEM_WIN   = 2,
  parameter int SIZE_CODE_MAX = 11
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cfg_we_i,
  input  logic [$clog2(2*NUM_MEM_WIN+2)-1:0]    cfg_sel_i,
  input  logic [31:0]                           cfg_wdata_i,
  input  logic                                  lb_req_i,
  input  logic [31:0]                           lb_addr_i,
  output logic                                  out_vld_o,
  output logic                                  hit_o,
  output logic                                  miss_o,
  output logic [$clog2(NUM_MEM_WIN+1)-1:0]      win_o,
  output logic [31:0]                           pci_addr_o,
  output logic [2:0]                            cyc_type_o,
  output logic                                  prefetch_o,
  output logic                                  ad_low_o,
  output logic [1:0]                            swap_o
);
  localparam int NWIN  = NUM_MEM_WIN + 1;
  localparam int SEL_W = $clog2(2 * NUM_MEM_WIN + 2);
  localparam int WIN_W = $clog2(NWIN);

  mem_cfg_t mem_cfg [NUM_MEM_WIN];
  io_cfg_t  io_cfg;
  xres_t    res     [NWIN];

  lpw_regfile #(.NUM_MEM_WIN(NUM_MEM_WIN), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we_i),
    .cfg_sel   (cfg_sel_i),
    .cfg_wdata (cfg_wdata_i),
    .mem_cfg   (mem_cfg),
    .io_cfg    (io_cfg)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    if (w < NUM_MEM_WIN) begin : g_mem
      lpw_mem_win #(.SIZE_CODE_MAX(SIZE_CODE_MAX)) u_win (
        .cfg  (mem_cfg[w]),
        .addr (lb_addr_i),
        .res  (res[w])
      );
    end else begin : g_io
      lpw_io_win u_win (
        .cfg  (io_cfg),
        .addr (lb_addr_i),
        .res  (res[w])
      );
    end
  end

  lpw_pick #(.NWIN(NWIN), .WIN_W(WIN_W)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .req     (lb_req_i),
    .res     (res),
    .out_vld (out_vld_o),
    .hit     (hit_o),
    .miss    (miss_o),
    .win     (win_o),
    .pa      (pci_addr_o),
    .typ     (cyc_type_o),
    .pf      (prefetch_o),
    .low     (ad_low_o),
    .swap    (swap_o)
  );

  a_r4_low_bits_pass: assert property (@(posedge clk) disable iff (rst)
    (hit_o && win_o < WIN_W'(NUM_MEM_WIN)) |->
      pci_addr_o[GRAN_LSB-1:0] == $past(lb_addr_i[GRAN_LSB-1:0]));
  a_r5_io_window: assert property (@(posedge clk) disable iff (rst)
    (hit_o && win_o == WIN_W'(NUM_MEM_WIN)) |->
      (cyc_type_o == CYC_IO && !prefetch_o && !ad_low_o &&
       pci_addr_o[IO_LSB-1:0] == $past(lb_addr_i[IO_LSB-1:0])));
endmodule

// File: tb/sim_lpw_xlate.sv
module sim_lpw_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        lb_req = 1'b0;
  logic [31:0] lb_addr = '0;
  logic        out_vld, hit, miss, prefetch, ad_low;
  logic [1:0]  win, swap;
  logic [31:0] pci_addr;
  logic [2:0]  cyc_type;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] bs [3];
  logic [15:0] ms [3];

  always #10 clk = ~clk;

  lpw_xlate u0 (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .lb_req_i(lb_req), .lb_addr_i(lb_addr),
    .out_vld_o(out_vld), .hit_o(hit), .miss_o(miss), .win_o(win),
    .pci_addr_o(pci_addr), .cyc_type_o(cyc_type), .prefetch_o(prefetch),
    .ad_low_o(ad_low), .swap_o(swap)
  );

  // expected result {vld,hit,miss,win,pa,typ,pf,low,swap} by interval arithmetic
  function automatic logic [43:0] model(input logic [31:0] a, input bit vld);
    longint unsigned span, lo, mp, av;
    logic [31:0] pa = '0;
    logic [1:0]  wi = '0, sw = '0;
    logic [2:0]  ty = '0;
    logic        pf = 1'b0, lw = 1'b0, found = 1'b0;
    int s;
    av = longint'(a);
    for (int w = 0; w < 2; w++) begin
      if (!found && bs[w][0]) begin
        s = int'(bs[w][7:4]);
        if (s > 11) s = 11;
        span = 64'd1 << (20 + s);
        lo   = (longint'(bs[w][31:20]) << 20) / span * span;
        if (av >= lo && av < lo + span) begin
          found = 1'b1;
          wi = 2'(w);
          mp = (longint'(ms[w][15:4]) << 20) / span * span;
          pa = 32'(mp + (av - lo));
          ty = ms[w][3:1];
          pf = bs[w][3];
          lw = ms[w][0];
          sw = bs[w][9:8];
        end
      end
    end
    if (!found && bs[2][0]) begin
      lo = longint'(bs[2][15:8]) << 24;
      if (av >= lo && av < lo + 64'd16777216) begin
        found = 1'b1;
        wi = 2'd2;
        pa = 32'((longint'(ms[2][15:8]) << 24) + (av - lo));
        ty = 3'd1;
        sw = bs[2][7:6];
      end
    end
    if (!vld) return '0;
    return {1'b1, found, !found, wi, pa, ty, pf, lw, sw};
  endfunction

  function automatic logic [43:0] actual();
    return {out_vld, hit, miss, win, pci_addr, cyc_type, prefetch, ad_low, swap};
  endfunction

  task automatic check(input string rq, input logic [43:0] act, input logic [43:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", rq, lb_addr, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel[0]) ms[sel[2:1]] = d[15:0];
    else        bs[sel[2:1]] = d;
  endtask

  task automatic look(input logic [31:0] a, input string rq);
    @(negedge clk);
    lb_req = 1'b1; lb_addr = a;
    @(negedge clk);
    lb_req = 1'b0;
    check(rq, actual(), model(a, 1'b1));
  endtask

  task automatic clear_shadow();
    for (int i = 0; i < 3; i++) begin bs[i] = '0; ms[i] = '0; end
  endtask

  task automatic sweep_top(input string rq);
    for (int k = 0; k < 256; k++)
      look({8'(k), 24'h0ABCDE ^ 24'(k * 24'h010203)}, rq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint unsigned span, lo;
    logic [31:0] b;
    clear_shadow();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: idle outputs are all zero
    check("R8", actual(), 44'd0);
    // R1: everything misses right after reset
    look(32'h0000_0000, "R1");
    look(32'h4000_0000, "R1");
    look(32'hFFFF_FFFF, "R1");
    // R2: fields written but enable left clear, never matches
    wr(3'd0, 32'h4000_0080);
    wr(3'd1, 32'h0000_0006);
    look(32'h4000_0000, "R2");
    look(32'h4123_4567, "R7");
    // R2: a write is used by the lookup in the next cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h4000_0081;
    @(negedge clk);
    cfg_we = 1'b0; bs[0] = 32'h4000_0081;
    lb_req = 1'b1; lb_addr = 32'h4765_4321;
    @(negedge clk);
    lb_req = 1'b0;
    check("R2", actual(), model(32'h4765_4321, 1'b1));
    // R3 R4 R9: every size code, edges inside and outside the span
    for (int c = 0; c < 16; c++) begin
      int s;
      s = (c > 11) ? 11 : c;
      b = {12'h4A5, 10'd0, 2'(c), 4'(c), 1'(c), 2'b00, 1'b1};
      wr(3'd0, b);
      wr(3'd1, {16'd0, 12'hC3A, 3'((c % 2 == 0) ? 3 : 6), 1'(c >> 1)});
      span = 64'd1 << (20 + s);
      lo   = (64'h4A5 << 20) / span * span;
      look(32'(lo), "R3");
      look(32'(lo + span - 1), "R3");
      look(32'(lo + span), "R3");
      look(32'(lo - 1), "R3");
      look(32'(lo + ((64'h9E3779B9 * longint'(c + 1)) % span)), "R4");
      look(32'(lo + ((64'h7F4A7C15 * longint'(c + 3)) % span)), "R9");
    end
    // R4: each cycle type code passes through
    for (int t = 0; t < 8; t++) begin
      wr(3'd1, {16'd0, 12'h123, 3'(t), 1'(t)});
      look(32'h4123_4567, "R4");
    end
    // R6: standard three-window layout
    wr(3'd0, 32'h4000_0081);
    wr(3'd1, 32'h0000_0006);
    wr(3'd2, 32'h5000_0289);
    wr(3'd3, 32'h0000_100C);
    wr(3'd4, 32'h0000_6041);
    wr(3'd5, 32'h0000_0000);
    sweep_top("R6");
    // R6: window 0 grown to 512 MB hides window 1
    wr(3'd0, 32'h4000_0091);
    sweep_top("R6");
    // R6: window 1 reprogrammed while hidden, then exposed elsewhere
    wr(3'd2, 32'h6100_0041);
    wr(3'd3, 32'h0000_000A);
    sweep_top("R6");
    look(32'h6100_1234, "R6");
    // R5: I/O window with a different map and swap; overlap of window 1 removed
    wr(3'd2, 32'h5000_0289);
    wr(3'd3, 32'h0000_100C);
    wr(3'd0, 32'h4000_0081);
    wr(3'd4, 32'h0000_A5C1);
    wr(3'd5, 32'h0000_7E00);
    for (int k = 0; k < 16; k++)
      look({8'hA5, 24'(k * 24'h111111)}, "R5");
    look(32'hA4FF_FFFF, "R5");
    look(32'hA600_0000, "R5");
    wr(3'd4, 32'h0000_A5C0);
    look(32'hA500_0010, "R5");
    // R1: reset in mid-run clears the windows
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_shadow();
    check("R1", actual(), 44'd0);
    look(32'h4000_0000, "R1");
    look(32'h5000_0000, "R1");
    look(32'h6000_0000, "R7");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule